// File: doc/BRIEF.md
# Three-Slot Bundle Group Dispatcher

The dispatcher accepts one 128-bit instruction bundle at a time over a valid/ready handshake. Each bundle carries three 41-bit slots and a 5-bit template code. The code fixes the execution-unit kind expected in every slot and the places where a parallel group must end. The block walks the slots in order and gathers them into an instruction group that may continue across any number of bundles. When a group ends, it presents the whole group in one cycle on a per-unit valid vector, with each valid unit carrying the slot it received.

The group models a fixed set of execution units: memory units, integer units, floating-point units and branch units. Their counts are parameters, by default 2, 2, 2 and 3. A generic ALU operation can sit in a memory or an integer position and is steered to whichever of those two unit kinds still has room. If a slot does not fit in the current group, the group closes early and the slot opens the next one. One template code fuses its last two slots into a single integer-unit operation that carries a wide immediate.

Top module: `bdl_dispatch`

## Requirements
- R1: The template code is bundle bits [4:0]. Slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. Slots are processed in the order 0, 1, 2, and units of one kind are filled from the lowest index upward in that order.
- R2: Template code = {combo[3:0], end_stop}. end_stop=1 places a stop after slot 2. The combos are: 0 M,I,I; 1 M,I,I with a stop after slot 1; 2 M,I,I with a stop after slot 0; 3 M,M,I; 4 M,M,I with a stop after slot 0; 5 M,F,I; 6 M,M,F; 7 M,I,B; 8 M,M,B; 9 M,F,B; 10 M,B,B; 11 B,B,B; 12 M,L,X. Codes 26 to 31 are illegal: the bundle is accepted and dropped, illegal_o pulses for one cycle in the following cycle, and the open group is left unchanged.
- R3: M, I, F and B slots go to memory, integer, floating-point and branch units respectively. The unit index in unit_vld_o is memory units first, then integer, then floating-point, then branch (default 0-1, 2-3, 4-5, 6-8).
- R4: A slot in an M or I position whose bit 40 is 1 is a generic ALU operation. It takes an integer unit if one is free in the open group, and otherwise a memory unit.
- R5: A stop after a slot closes the group with that slot included. The group appears with issue_valid_o high in the cycle after the bundle cycle that reached the stop.
- R6: Without a stop, the open group carries on into the following bundles and nothing is issued.
- R7: A slot that finds no free unit of its kind closes the open group without that slot. In the next cycle the same bundle is processed again from that slot, with a new group.
- R8: In combo 12 the L and X slots form one operation on one integer unit. That unit's payload is the X slot (slot 2), and the L slot (slot 1) appears on that integer unit's lane of lx_imm_o with its lx_vld_o bit set.
- R9: bundle_ready_o is high when the current cycle uses up all remaining slots of a legal bundle, or when the bundle is illegal. Otherwise it stays low and the bundle must be held.
- R10: After reset no group is open, issue_valid_o, unit_vld_o, lx_vld_o and illegal_o are 0, and a bundle is processed from slot 0.
- R11: unit_vld_o and lx_vld_o are all zero in every cycle where issue_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bundle_i | input | 128 | Bundle: three slots and the template code |
| bundle_valid_i | input | 1 | Bundle present |
| bundle_ready_o | output | 1 | Bundle fully consumed this cycle |
| issue_valid_o | output | 1 | A closed group is presented |
| unit_vld_o | output | 9 | Per-unit occupancy of the presented group |
| unit_op_o | output | 369 | Per-unit slot payload, 41 bits per unit |
| lx_vld_o | output | 2 | Integer unit carries a fused long-immediate operation |
| lx_imm_o | output | 82 | Long-immediate slot for each integer unit |
| illegal_o | output | 1 | Dropped bundle with an unsupported template |

## Verification
The bench builds the block with its default parameters: 41-bit slots, two memory, two integer and two floating-point units, three branch units, and ALU operations preferring integer units. With these small counts, two bundles are enough to overflow the branch or memory units, and one M,I,I bundle fills both integer units so that a later ALU slot falls back to a memory unit. The directed scenarios cover inner and end stops, groups that span bundles, re-entry of a bundle after an overflow, the fused long-immediate template, and an illegal code placed in the middle of an open group.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   typedef enum logic [2:0] {
      ST_M = 3'd0,
      ST_I = 3'd1,
      ST_F = 3'd2,
      ST_B = 3'd3,
      ST_L = 3'd4,
      ST_X = 3'd5
   } slot_type_e;

   typedef enum logic [2:0] {
      CL_M    = 3'd0,
      CL_I    = 3'd1,
      CL_F    = 3'd2,
      CL_B    = 3'd3,
      CL_NONE = 3'd4,
      CL_OVF  = 3'd5
   } unit_cls_e;

   localparam int SLOTS = 3;

endpackage

// File: rtl/bdl_tmpl_decode.sv
module bdl_tmpl_decode
   import bdl_pkg::*;
#(
   parameter int TMPL_W = 5
) (
   input  logic [TMPL_W-1:0] tmpl_i,
   output logic              legal_o,
   output slot_type_e        types_o [SLOTS],
   output logic [SLOTS-1:0]  stop_o
);

   if (TMPL_W != 5) begin : g_bad_tmpl
      $error("bdl_tmpl_decode: template width must be 5");
   end

   logic [3:0] combo;
   assign combo = tmpl_i[4:1];

   always_comb begin
      legal_o    = 1'b1;
      stop_o     = {tmpl_i[0], 2'b00};
      types_o[0] = ST_M;
      types_o[1] = ST_I;
      types_o[2] = ST_I;
      unique case (combo)
         4'd0: ;
         4'd1: stop_o[1] = 1'b1;
         4'd2: stop_o[0] = 1'b1;
         4'd3: types_o[1] = ST_M;
         4'd4: begin
            types_o[1] = ST_M;
            stop_o[0]  = 1'b1;
         end
         4'd5: types_o[1] = ST_F;
         4'd6: begin
            types_o[1] = ST_M;
            types_o[2] = ST_F;
         end
         4'd7: types_o[2] = ST_B;
         4'd8: begin
            types_o[1] = ST_M;
            types_o[2] = ST_B;
         end
         4'd9: begin
            types_o[1] = ST_F;
            types_o[2] = ST_B;
         end
         4'd10: begin
            types_o[1] = ST_B;
            types_o[2] = ST_B;
         end
         4'd11: begin
            types_o[0] = ST_B;
            types_o[1] = ST_B;
            types_o[2] = ST_B;
         end
         4'd12: begin
            types_o[1] = ST_L;
            types_o[2] = ST_X;
         end
         default: begin
            legal_o = 1'b0;
            stop_o  = '0;
         end
      endcase
   end

endmodule

// File: rtl/bdl_group_walk.sv
module bdl_group_walk
   import bdl_pkg::*;
#(
   parameter int NUM_M          = 2,
   parameter int NUM_I          = 2,
   parameter int NUM_F          = 2,
   parameter int NUM_B          = 3,
   parameter int CNT_W          = 4,
   parameter int UIX_W          = 4,
   parameter bit ALU_PREFER_INT = 1'b1
) (
   input  slot_type_e         types_i [SLOTS],
   input  logic [SLOTS-1:0]   alu_i,
   input  logic [SLOTS-1:0]   stop_i,
   input  logic [1:0]         pos_i,
   input  logic [CNT_W-1:0]   cnt_m_i,
   input  logic [CNT_W-1:0]   cnt_i_i,
   input  logic [CNT_W-1:0]   cnt_f_i,
   input  logic [CNT_W-1:0]   cnt_b_i,
   output logic [SLOTS-1:0]   take_o,
   output logic [SLOTS-1:0]   has_unit_o,
   output logic [SLOTS-1:0]   fused_o,
   output logic [UIX_W-1:0]   unit_o [SLOTS],
   output logic               issue_o,
   output logic [1:0]         next_pos_o
);

   localparam int M_BASE = 0;
   localparam int I_BASE = NUM_M;
   localparam int F_BASE = I_BASE + NUM_I;
   localparam int B_BASE = F_BASE + NUM_F;

   always_comb begin
      logic [CNT_W-1:0] cm, ci, cf, cb;
      logic             done, m_ok, i_ok, f_ok, b_ok;
      unit_cls_e        sel;
      cm = cnt_m_i;
      ci = cnt_i_i;
      cf = cnt_f_i;
      cb = cnt_b_i;
      done       = 1'b0;
      issue_o    = 1'b0;
      next_pos_o = 2'd3;
      for (int k = 0; k < SLOTS; k++) begin
         take_o[k]     = 1'b0;
         has_unit_o[k] = 1'b0;
         fused_o[k]    = 1'b0;
         unit_o[k]     = '0;
         m_ok = (cm < CNT_W'(NUM_M));
         i_ok = (ci < CNT_W'(NUM_I));
         f_ok = (cf < CNT_W'(NUM_F));
         b_ok = (cb < CNT_W'(NUM_B));
         sel  = CL_NONE;
         if (!done && (k >= int'(pos_i))) begin
            unique case (types_i[k])
               ST_M, ST_I: begin
                  if (alu_i[k]) begin
                     if (ALU_PREFER_INT)
                        sel = i_ok ? CL_I : (m_ok ? CL_M : CL_OVF);
                     else
                        sel = m_ok ? CL_M : (i_ok ? CL_I : CL_OVF);
                  end else if (types_i[k] == ST_M) begin
                     sel = m_ok ? CL_M : CL_OVF;
                  end else begin
                     sel = i_ok ? CL_I : CL_OVF;
                  end
               end
               ST_F:    sel = f_ok ? CL_F : CL_OVF;
               ST_B:    sel = b_ok ? CL_B : CL_OVF;
               ST_L:    sel = i_ok ? CL_I : CL_OVF;
               default: sel = CL_NONE;
            endcase
            if (sel == CL_OVF) begin
               issue_o    = 1'b1;
               done       = 1'b1;
               next_pos_o = 2'(k);
            end else begin
               take_o[k]  = 1'b1;
               fused_o[k] = (types_i[k] == ST_L);
               unique case (sel)
                  CL_M: begin
                     unit_o[k]     = UIX_W'(M_BASE) + UIX_W'(cm);
                     has_unit_o[k] = 1'b1;
                     cm            = cm + 1'b1;
                  end
                  CL_I: begin
                     unit_o[k]     = UIX_W'(I_BASE) + UIX_W'(ci);
                     has_unit_o[k] = 1'b1;
                     ci            = ci + 1'b1;
                  end
                  CL_F: begin
                     unit_o[k]     = UIX_W'(F_BASE) + UIX_W'(cf);
                     has_unit_o[k] = 1'b1;
                     cf            = cf + 1'b1;
                  end
                  CL_B: begin
                     unit_o[k]     = UIX_W'(B_BASE) + UIX_W'(cb);
                     has_unit_o[k] = 1'b1;
                     cb            = cb + 1'b1;
                  end
                  default: ;
               endcase
               if (stop_i[k]) begin
                  issue_o    = 1'b1;
                  done       = 1'b1;
                  next_pos_o = 2'(k + 1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/bdl_dispatch.sv
module bdl_dispatch
   import bdl_pkg::*;
#(
   parameter int SLOT_W         = 41,
   parameter int TMPL_W         = 5,
   parameter int NUM_M          = 2,
   parameter int NUM_I          = 2,
   parameter int NUM_F          = 2,
   parameter int NUM_B          = 3,
   parameter bit ALU_PREFER_INT = 1'b1,
   localparam int BUNDLE_W      = SLOTS * SLOT_W + TMPL_W,
   localparam int NU            = NUM_M + NUM_I + NUM_F + NUM_B
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [BUNDLE_W-1:0]    bundle_i,
   input  logic                   bundle_valid_i,
   output logic                   bundle_ready_o,
   output logic                   issue_valid_o,
   output logic [NU-1:0]          unit_vld_o,
   output logic [NU*SLOT_W-1:0]   unit_op_o,
   output logic [NUM_I-1:0]       lx_vld_o,
   output logic [NUM_I*SLOT_W-1:0] lx_imm_o,
   output logic                   illegal_o
);

   localparam int M_BASE = 0;
   localparam int I_BASE = NUM_M;
   localparam int F_BASE = I_BASE + NUM_I;
   localparam int B_BASE = F_BASE + NUM_F;
   localparam int UIX_W  = (NU > 1) ? $clog2(NU) : 1;
   localparam int CNT_W  = $clog2(NU + 1);

   if (NUM_M < 1 || NUM_I < 1 || NUM_F < 1 || NUM_B < 3) begin : g_bad_units
      $error("bdl_dispatch: need at least one M, I, F unit and three B units");
   end
   if (SLOT_W < 2) begin : g_bad_slot
      $error("bdl_dispatch: slot width too small");
   end

   // slot extraction
   logic [SLOT_W-1:0] slot [SLOTS];
   logic [SLOTS-1:0]  alu;
   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign slot[k] = bundle_i[TMPL_W + k*SLOT_W +: SLOT_W];
      assign alu[k]  = slot[k][SLOT_W-1];
   end

   // template decode
   logic             legal;
   slot_type_e       types [SLOTS];
   logic [SLOTS-1:0] stops;

   bdl_tmpl_decode #(.TMPL_W(TMPL_W)) u_dec (
      .tmpl_i  (bundle_i[TMPL_W-1:0]),
      .legal_o (legal),
      .types_o (types),
      .stop_o  (stops)
   );

   // open group state
   logic [NU-1:0]     acc_vld;
   logic [SLOT_W-1:0] acc_op [NU];
   logic [NUM_I-1:0]  acc_lxv;
   logic [SLOT_W-1:0] acc_lx [NUM_I];
   logic [1:0]        pos_q;

   logic [CNT_W-1:0] cnt_m, cnt_i, cnt_f, cnt_b;
   always_comb begin
      cnt_m = '0;
      cnt_i = '0;
      cnt_f = '0;
      cnt_b = '0;
      for (int u = 0; u < NUM_M; u++) cnt_m = cnt_m + CNT_W'(acc_vld[M_BASE+u]);
      for (int u = 0; u < NUM_I; u++) cnt_i = cnt_i + CNT_W'(acc_vld[I_BASE+u]);
      for (int u = 0; u < NUM_F; u++) cnt_f = cnt_f + CNT_W'(acc_vld[F_BASE+u]);
      for (int u = 0; u < NUM_B; u++) cnt_b = cnt_b + CNT_W'(acc_vld[B_BASE+u]);
   end

   // slot walk
   logic [SLOTS-1:0] take, has_unit, fused;
   logic [UIX_W-1:0] unit_ix [SLOTS];
   logic             issue_ev;
   logic [1:0]       next_pos;

   bdl_group_walk #(
      .NUM_M          (NUM_M),
      .NUM_I          (NUM_I),
      .NUM_F          (NUM_F),
      .NUM_B          (NUM_B),
      .CNT_W          (CNT_W),
      .UIX_W          (UIX_W),
      .ALU_PREFER_INT (ALU_PREFER_INT)
   ) u_walk (
      .types_i    (types),
      .alu_i      (alu),
      .stop_i     (stops),
      .pos_i      (pos_q),
      .cnt_m_i    (cnt_m),
      .cnt_i_i    (cnt_i),
      .cnt_f_i    (cnt_f),
      .cnt_b_i    (cnt_b),
      .take_o     (take),
      .has_unit_o (has_unit),
      .fused_o    (fused),
      .unit_o     (unit_ix),
      .issue_o    (issue_ev),
      .next_pos_o (next_pos)
   );

   // merge taken slots into the open group
   logic [NU-1:0]     nv;
   logic [SLOT_W-1:0] nop [NU];
   logic [NUM_I-1:0]  nlxv;
   logic [SLOT_W-1:0] nlx [NUM_I];

   always_comb begin
      nv   = acc_vld;
      nop  = acc_op;
      nlxv = acc_lxv;
      nlx  = acc_lx;
      for (int k = 0; k < SLOTS; k++) begin
         for (int u = 0; u < NU; u++) begin
            if (take[k] && has_unit[k] && (unit_ix[k] == UIX_W'(u))) begin
               nv[u]  = 1'b1;
               nop[u] = fused[k] ? slot[SLOTS-1] : slot[k];
            end
         end
         for (int j = 0; j < NUM_I; j++) begin
            if (take[k] && fused[k] && (unit_ix[k] == UIX_W'(I_BASE + j))) begin
               nlxv[j] = 1'b1;
               nlx[j]  = slot[k];
            end
         end
      end
   end

   assign bundle_ready_o = !legal || (next_pos == 2'd3);

   // issue registers
   logic              iss_q, ill_q;
   logic [NU-1:0]     out_vld;
   logic [SLOT_W-1:0] out_op [NU];
   logic [NUM_I-1:0]  out_lxv;
   logic [SLOT_W-1:0] out_lx [NUM_I];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         iss_q   <= 1'b0;
         ill_q   <= 1'b0;
         pos_q   <= 2'd0;
         acc_vld <= '0;
         acc_lxv <= '0;
         out_vld <= '0;
         out_lxv <= '0;
         for (int u = 0; u < NU; u++) begin
            acc_op[u] <= '0;
            out_op[u] <= '0;
         end
         for (int j = 0; j < NUM_I; j++) begin
            acc_lx[j] <= '0;
            out_lx[j] <= '0;
         end
      end else begin
         ill_q   <= bundle_valid_i && !legal;
         iss_q   <= 1'b0;
         out_vld <= '0;
         out_lxv <= '0;
         if (bundle_valid_i && legal) begin
            pos_q <= (next_pos == 2'd3) ? 2'd0 : next_pos;
            if (issue_ev) begin
               iss_q   <= 1'b1;
               out_vld <= nv;
               out_op  <= nop;
               out_lxv <= nlxv;
               out_lx  <= nlx;
               acc_vld <= '0;
               acc_lxv <= '0;
            end else begin
               acc_vld <= nv;
               acc_op  <= nop;
               acc_lxv <= nlxv;
               acc_lx  <= nlx;
            end
         end
      end
   end

   assign issue_valid_o = iss_q;
   assign illegal_o     = ill_q;
   assign unit_vld_o    = out_vld;
   assign lx_vld_o      = out_lxv;

   for (genvar u = 0; u < NU; u++) begin : g_uout
      assign unit_op_o[u*SLOT_W +: SLOT_W] = out_op[u];
   end
   for (genvar j = 0; j < NUM_I; j++) begin : g_lxout
      assign lx_imm_o[j*SLOT_W +: SLOT_W] = out_lx[j];
   end

endmodule

// File: rtl/bdl_dispatch_chk.sv
module bdl_dispatch_chk #(
   parameter int NUM_M = 2,
   parameter int NUM_I = 2,
   parameter int NUM_F = 2,
   parameter int NUM_B = 3,
   localparam int NU   = NUM_M + NUM_I + NUM_F + NUM_B
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bundle_valid_i,
   input logic             bundle_ready_o,
   input logic             issue_valid_o,
   input logic [NU-1:0]    unit_vld_o,
   input logic [NUM_I-1:0] lx_vld_o,
   input logic             illegal_o
);

   localparam int I_BASE = NUM_M;
   localparam int F_BASE = I_BASE + NUM_I;
   localparam int B_BASE = F_BASE + NUM_F;

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !issue_valid_o |-> (unit_vld_o == '0) && (lx_vld_o == '0)); // R11

   AST_GROUP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o |-> (unit_vld_o != '0)); // R5

   AST_ILLEGAL_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> !issue_valid_o); // R2

   AST_HOLD_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bundle_valid_i && !bundle_ready_o) |=> issue_valid_o); // R9

   for (genvar j = 0; j < NUM_I; j++) begin : g_lx
      AST_LX_ON_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         lx_vld_o[j] |-> unit_vld_o[I_BASE+j]); // R8
   end

   for (genvar u = 1; u < NU; u++) begin : g_fill
      if (u != I_BASE && u != F_BASE && u != B_BASE) begin : g_inner
         AST_FILL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
            unit_vld_o[u] |-> unit_vld_o[u-1]); // R3
      end
   end

endmodule

bind bdl_dispatch bdl_dispatch_chk #(
   .NUM_M (NUM_M),
   .NUM_I (NUM_I),
   .NUM_F (NUM_F),
   .NUM_B (NUM_B)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .bundle_valid_i (bundle_valid_i),
   .bundle_ready_o (bundle_ready_o),
   .issue_valid_o  (issue_valid_o),
   .unit_vld_o     (unit_vld_o),
   .lx_vld_o       (lx_vld_o),
   .illegal_o      (illegal_o)
);

// File: tb/tb_bdl_dispatch.sv
module tb_bdl_dispatch;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 41;
   localparam int NU = 9;
   localparam int NI = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [127:0]      bundle = '0;
   logic              valid = 1'b0;
   logic              ready, issue_valid, illegal;
   logic [NU-1:0]     unit_vld;
   logic [NU*SW-1:0]  unit_op;
   logic [NI-1:0]     lx_vld;
   logic [NI*SW-1:0]  lx_imm;

   always #(CLK_PERIOD/2) clk = ~clk;

   bdl_dispatch dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .bundle_i       (bundle),
      .bundle_valid_i (valid),
      .bundle_ready_o (ready),
      .issue_valid_o  (issue_valid),
      .unit_vld_o     (unit_vld),
      .unit_op_o      (unit_op),
      .lx_vld_o       (lx_vld),
      .lx_imm_o       (lx_imm),
      .illegal_o      (illegal)
   );

   int checks = 0;
   int errors = 0;

   // issued-group capture
   int              ngrp = 0;
   int              nill = 0;
   int              idle_bad = 0;
   logic [NU-1:0]   cap_vld [64];
   logic [SW-1:0]   cap_op  [64][NU];
   logic [NI-1:0]   cap_lxv [64];
   logic [SW-1:0]   cap_lx  [64][NI];
   logic [SW-1:0]   exp_op  [NU];

   always @(negedge clk) begin
      if (rst_n) begin
         if (issue_valid && ngrp < 64) begin
            cap_vld[ngrp] = unit_vld;
            cap_lxv[ngrp] = lx_vld;
            for (int u = 0; u < NU; u++) cap_op[ngrp][u] = unit_op[u*SW +: SW];
            for (int j = 0; j < NI; j++) cap_lx[ngrp][j] = lx_imm[j*SW +: SW];
            ngrp = ngrp + 1;
         end
         if (!issue_valid && (unit_vld != '0 || lx_vld != '0)) idle_bad = idle_bad + 1;
         if (illegal) nill = nill + 1;
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] pl(input int n);
      return {1'b0, 40'(n * 37 + 5)};
   endfunction

   function automatic logic [SW-1:0] al(input int n);
      return {1'b1, 40'(n * 53 + 9)};
   endfunction

   task automatic clr_exp();
      for (int u = 0; u < NU; u++) exp_op[u] = '0;
   endtask

   task automatic check_grp(input int g, input logic [NU-1:0] vld, input string req);
      chk({req, " group valid vector"}, 64'(cap_vld[g]), 64'(vld));
      for (int u = 0; u < NU; u++)
         if (vld[u]) chk({req, " unit payload"}, 64'(cap_op[g][u]), 64'(exp_op[u]));
   endtask

   // drive one bundle (called at a negedge), return cycles held
   task automatic push(input logic [4:0] t, input logic [SW-1:0] s0, s1, s2, output int cyc);
      bundle = {s2, s1, s0, t};
      valid  = 1'b1;
      cyc    = 1;
      #1;
      while (!ready) begin
         @(negedge clk);
         #1;
         cyc++;
      end
      @(negedge clk);
      valid = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      #1;
   endtask

   // R10: reset state
   task automatic t_reset();
      chk("R10 issue_valid after reset", 64'(issue_valid), 64'd0);
      chk("R10 unit_vld after reset", 64'(unit_vld), 64'd0);
      chk("R10 lx_vld after reset", 64'(lx_vld), 64'd0);
      chk("R10 illegal after reset", 64'(illegal), 64'd0);
      chk("R10 ready with empty group", 64'(ready), 64'd1);
   endtask

   // R1 R3 R5: single bundle, end stop
   task automatic t_end_stop();
      int b, c;
      b = ngrp;
      clr_exp();
      exp_op[0] = pl(1); exp_op[2] = pl(2); exp_op[3] = pl(3);
      push(5'd1, pl(1), pl(2), pl(3), c);
      #1;
      chk("R5 issue one cycle after stop", 64'(issue_valid), 64'd1);
      drain();
      chk("R5 group count", 64'(ngrp - b), 64'd1);
      check_grp(b, 9'h00D, "R1 R3");
   endtask

   // R6: group spans two bundles
   task automatic t_span();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd10, pl(10), pl(11), pl(12), c);
      drain();
      chk("R6 no issue without stop", 64'(ngrp - b), 64'd0);
      exp_op[0] = pl(10); exp_op[4] = pl(11); exp_op[2] = pl(12);
      exp_op[1] = pl(13); exp_op[3] = pl(14); exp_op[6] = pl(15);
      push(5'd15, pl(13), pl(14), pl(15), c);
      drain();
      chk("R6 one spanning group", 64'(ngrp - b), 64'd1);
      check_grp(b, 9'h05F, "R6");
   endtask

   // R2 R5 R9: inner stop positions
   task automatic t_inner_stop();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd8, pl(20), pl(21), pl(22), c);
      chk("R9 inner stop holds bundle two cycles", 64'(c), 64'd2);
      push(5'd23, pl(23), pl(24), pl(25), c);
      drain();
      chk("R2 inner stop group count", 64'(ngrp - b), 64'd2);
      exp_op[0] = pl(20);
      check_grp(b, 9'h001, "R2 stop after slot0");
      clr_exp();
      exp_op[0] = pl(21); exp_op[2] = pl(22);
      exp_op[6] = pl(23); exp_op[7] = pl(24); exp_op[8] = pl(25);
      check_grp(b + 1, 9'h1C5, "R2 R5");
      b = ngrp;
      push(5'd3, pl(26), pl(27), pl(28), c);
      drain();
      chk("R2 stop after slot1 group count", 64'(ngrp - b), 64'd2);
      clr_exp();
      exp_op[0] = pl(26); exp_op[2] = pl(27);
      check_grp(b, 9'h005, "R2 stop after slot1");
      clr_exp();
      exp_op[2] = pl(28);
      check_grp(b + 1, 9'h004, "R2 trailing group");
   endtask

   // R7: memory overflow splits the group
   task automatic t_overflow_m();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd12, pl(30), pl(31), pl(32), c);
      push(5'd17, pl(33), pl(34), pl(35), c);
      chk("R7 overflow bundle re-entered", 64'(c), 64'd2);
      drain();
      chk("R7 overflow group count", 64'(ngrp - b), 64'd2);
      exp_op[0] = pl(30); exp_op[1] = pl(31); exp_op[4] = pl(32);
      check_grp(b, 9'h013, "R7 first");
      clr_exp();
      exp_op[0] = pl(33); exp_op[1] = pl(34); exp_op[6] = pl(35);
      check_grp(b + 1, 9'h043, "R7 second");
   endtask

   // R7: branch overflow in mid-bundle
   task automatic t_overflow_b();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd20, pl(40), pl(41), pl(42), c);
      push(5'd23, pl(43), pl(44), pl(45), c);
      chk("R7 branch overflow re-entry", 64'(c), 64'd2);
      drain();
      chk("R7 branch group count", 64'(ngrp - b), 64'd2);
      exp_op[0] = pl(40); exp_op[6] = pl(41); exp_op[7] = pl(42); exp_op[8] = pl(43);
      check_grp(b, 9'h1C1, "R7 branch full");
      clr_exp();
      exp_op[6] = pl(44); exp_op[7] = pl(45);
      check_grp(b + 1, 9'h0C0, "R7 branch rest");
   endtask

   // R4: ALU steering
   task automatic t_alu();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd7, al(50), pl(51), pl(52), c);
      drain();
      exp_op[2] = al(50); exp_op[0] = pl(51); exp_op[3] = pl(52);
      check_grp(b, 9'h00D, "R4 alu to free int");
      b = ngrp;
      clr_exp();
      push(5'd0, pl(53), pl(54), pl(55), c);
      push(5'd19, al(56), pl(57), pl(58), c);
      drain();
      chk("R4 group count", 64'(ngrp - b), 64'd1);
      exp_op[0] = pl(53); exp_op[2] = pl(54); exp_op[3] = pl(55);
      exp_op[1] = al(56); exp_op[4] = pl(57); exp_op[6] = pl(58);
      check_grp(b, 9'h05F, "R4 alu falls to memory");
   endtask

   // R8: fused long immediate
   task automatic t_lx();
      int b, c;
      b = ngrp;
      clr_exp();
      push(5'd25, pl(60), pl(61), pl(62), c);
      drain();
      exp_op[0] = pl(60); exp_op[2] = pl(62);
      check_grp(b, 9'h005, "R8");
      chk("R8 lx valid lane", 64'(cap_lxv[b]), 64'd1);
      chk("R8 lx immediate", 64'(cap_lx[b][0]), 64'(pl(61)));
   endtask

   // R2: illegal template dropped, open group untouched
   task automatic t_illegal();
      int b, c, i0;
      b  = ngrp;
      i0 = nill;
      clr_exp();
      push(5'd0, pl(70), pl(71), pl(72), c);
      push(5'd26, pl(90), pl(91), pl(92), c);
      drain();
      chk("R2 illegal flagged", 64'(nill - i0), 64'd1);
      chk("R2 illegal issues nothing", 64'(ngrp - b), 64'd0);
      push(5'd31, pl(93), pl(94), pl(95), c);
      push(5'd23, pl(73), pl(74), pl(75), c);
      drain();
      chk("R2 second illegal flagged", 64'(nill - i0), 64'd2);
      exp_op[0] = pl(70); exp_op[2] = pl(71); exp_op[3] = pl(72);
      exp_op[6] = pl(73); exp_op[7] = pl(74); exp_op[8] = pl(75);
      check_grp(b, 9'h1CD, "R2 group unchanged");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_end_stop();
      t_span();
      t_inner_stop();
      t_overflow_m();
      t_overflow_b();
      t_alu();
      t_lx();
      t_illegal();
      chk("R11 unit valids quiet when idle", 64'(idle_bad), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule